// File: doc/BRIEF.md
# Triggered Decimating IQ Capture Buffers

This block keeps several independent snapshot memories of complex sample streams from a digital RF control loop that runs at 40 MHz. Each lane stores a stream of paired in-phase and quadrature words. Software arms a lane, and a shared pulse trigger starts it. After the trigger the lane waits a programmable number of input samples, called the pan. It then stores one sample out of every Z input samples, where Z is the zoom, until its memory is full. A full lane raises a done flag and holds its contents until it is armed again.

A host reads a finished lane through a simple address/enable port with two cycles of latency. Each lane has its own arm, zoom and pan. By default there are five lanes, each holding 512 entries of a 16-bit I word and a 16-bit Q word. The sample strobe marks which clock cycles carry a new input sample.

Top module: `iq_history_capture`

## Requirements
- R1: After reset every `done` bit is 0, `rd_valid` is 0, and `rd_i` and `rd_q` are 0.
- R2: A one-cycle pulse on `arm[b]` clears `done[b]` at the next clock edge and restarts that lane's write position at address 0. A `trigger` seen by a lane that is not armed has no effect.
- R3: For an armed lane, count the valid samples (`in_valid`=1) in cycles after the trigger cycle, starting from index 0. The first stored entry, at address 0, is the sample with index equal to that lane's pan.
- R4: Each later entry is the sample Zeff valid samples after the one before it, where Zeff is the lane's zoom, or 1 when the zoom is 0. Zoom and pan are sampled in the trigger cycle, and changes after that have no effect on the capture in progress.
- R5: When DEPTH entries have been stored, the lane stops writing. `done[b]` becomes 1 at the clock edge that stores the last entry. Samples after that point leave the memory unchanged.
- R6: Entry j of a lane holds the I word of the stored sample in the upper half and the Q word in the lower half, and it returns them on `rd_i` and `rd_q` respectively.
- R7: A read request (`rd_en`=1 with `rd_buf`, `rd_addr`) is served only when `rd_buf` names an existing lane whose `done` is 1. In that case `rd_valid` is 1 and the data appear after the second clock edge. Otherwise `rd_valid` is 0, and `rd_i` and `rd_q` are 0 whenever `rd_valid` is 0.
- R8: The lanes are independent. Arming, zoom and pan of one lane do not change the done flag or the stored data of another lane.
- R9: A trigger that arrives while a lane is capturing, or after it is done, does not restart that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a cycle that carries a new input sample |
| in_i | input | NUM_BUF*DW | In-phase word for each lane; lane b uses bits [b*DW +: DW] |
| in_q | input | NUM_BUF*DW | Quadrature word for each lane; same packing as in_i |
| trigger | input | 1 | Pulse trigger shared by all lanes |
| arm | input | NUM_BUF | Per-lane arm pulse |
| zoom | input | NUM_BUF*ZOOM_W | Per-lane decimation factor; 0 and 1 both store every sample |
| pan | input | NUM_BUF*PAN_W | Per-lane number of samples skipped after the trigger |
| done | output | NUM_BUF | Per-lane capture-complete flag |
| rd_en | input | 1 | Read request strobe |
| rd_buf | input | BW | Lane to read |
| rd_addr | input | AW | Entry address to read |
| rd_valid | output | 1 | Read data valid, two edges after an accepted request |
| rd_i | output | DW | I word read back |
| rd_q | output | DW | Q word read back |

## Verification
The bench builds the block with three lanes of 16 entries, a 3-bit zoom and a 4-bit pan. With this configuration, every zoom from 0 to 4 and pans up to 15 fill a lane within about 76 samples. That lets the bench sweep every combination and read back every entry. Each run gives the three lanes different settings and alternates a continuous sample strobe with a gapped one. The runs also retrigger mid-capture and change the zoom mid-capture. The bench checks the done flag on every cycle. The two-bit lane select can name a non-existent lane 3, so the bench can test that a read of a lane that does not exist is rejected.

// File: rtl/iq_hist_pkg.sv
package iq_hist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/iq_hist_ctrl.sv
module iq_hist_ctrl
  import iq_hist_pkg::*;
#(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned ZOOM_W = 8,
  parameter int unsigned PAN_W  = 12,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = max_u(ZOOM_W, PAN_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              valid_i,
  input  logic [ZOOM_W-1:0] zoom_i,
  input  logic [PAN_W-1:0]  pan_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic              done_o
);

  cap_state_t       state;
  logic [AW-1:0]    wptr;
  logic [CNT_W-1:0] skip;
  logic [CNT_W-1:0] gap;

  assign we_o    = (state == ST_RUN) && valid_i && (skip == '0);
  assign waddr_o = wptr;
  assign done_o  = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      wptr  <= '0;
      skip  <= '0;
      gap   <= '0;
    end else if (arm_i) begin
      state <= ST_ARMED;
      wptr  <= '0;
      skip  <= '0;
    end else begin
      case (state)
        ST_ARMED: begin
          if (trig_i) begin
            state <= ST_RUN;
            skip  <= CNT_W'(pan_i);
            gap   <= (zoom_i == '0) ? '0 : (CNT_W'(zoom_i) - CNT_W'(1));
          end
        end
        ST_RUN: begin
          if (valid_i) begin
            if (skip == '0) begin
              skip <= gap;
              if (wptr == AW'(DEPTH - 1)) state <= ST_DONE;
              else                        wptr  <= wptr + AW'(1);
            end else begin
              skip <= skip - CNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_ARM_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (!done_o && state == ST_ARMED)); // R2
  AST_IDLE_IGNORES_TRIG: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && trig_i && !arm_i) |=> (state == ST_IDLE)); // R2
  AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (we_o && $past(we_o) && !$past(arm_i)) |-> (waddr_o == AW'($past(waddr_o) + AW'(1)))); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> ($past(we_o) && $past(waddr_o) == AW'(DEPTH - 1))); // R5
  AST_RUN_IGNORES_TRIG: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && trig_i && !arm_i && skip != '0) |=> (state == ST_RUN)); // R9

endmodule

// File: rtl/iq_hist_ram.sv
module iq_hist_ram #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/iq_hist_rdsel.sv
module iq_hist_rdsel #(
  parameter int unsigned NUM_BUF = 5,
  parameter int unsigned W       = 32,
  localparam int unsigned BW     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      take_i,
  input  logic [BW-1:0]             sel_i,
  input  logic [NUM_BUF-1:0][W-1:0] bank_i,
  output logic                      valid_o,
  output logic [W-1:0]              data_o
);

  logic [W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (sel_i == BW'(b)) picked = bank_i[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= take_i;
      data_o  <= take_i ? picked : '0;
    end
  end

endmodule

// File: rtl/iq_history_capture.sv
module iq_history_capture #(
  parameter int unsigned NUM_BUF = 5,
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned DW      = 16,
  parameter int unsigned ZOOM_W  = 8,
  parameter int unsigned PAN_W   = 12,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned BW     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [NUM_BUF*DW-1:0]     in_i,
  input  logic [NUM_BUF*DW-1:0]     in_q,
  input  logic                      trigger,
  input  logic [NUM_BUF-1:0]        arm,
  input  logic [NUM_BUF*ZOOM_W-1:0] zoom,
  input  logic [NUM_BUF*PAN_W-1:0]  pan,
  output logic [NUM_BUF-1:0]        done,
  input  logic                      rd_en,
  input  logic [BW-1:0]             rd_buf,
  input  logic [AW-1:0]             rd_addr,
  output logic                      rd_valid,
  output logic [DW-1:0]             rd_i,
  output logic [DW-1:0]             rd_q
);

  localparam int unsigned EW = 2 * DW;

  logic [NUM_BUF-1:0]         lane_we;
  logic [AW-1:0]              lane_waddr [NUM_BUF];
  logic [NUM_BUF-1:0][EW-1:0] bank_rd;
  logic                       accept;
  logic                       acc_q;
  logic [BW-1:0]              sel_q;
  logic [EW-1:0]              rd_word;

  for (genvar gb = 0; gb < NUM_BUF; gb++) begin : g_lane
    iq_hist_ctrl #(
      .DEPTH (DEPTH),
      .ZOOM_W(ZOOM_W),
      .PAN_W (PAN_W)
    ) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .arm_i  (arm[gb]),
      .trig_i (trigger),
      .valid_i(in_valid),
      .zoom_i (zoom[gb*ZOOM_W +: ZOOM_W]),
      .pan_i  (pan[gb*PAN_W +: PAN_W]),
      .we_o   (lane_we[gb]),
      .waddr_o(lane_waddr[gb]),
      .done_o (done[gb])
    );

    iq_hist_ram #(
      .DEPTH(DEPTH),
      .W    (EW)
    ) u_ram (
      .clk    (clk),
      .we_i   (lane_we[gb]),
      .waddr_i(lane_waddr[gb]),
      .wdata_i({in_i[gb*DW +: DW], in_q[gb*DW +: DW]}),
      .re_i   (rd_en),
      .raddr_i(rd_addr),
      .rdata_o(bank_rd[gb])
    );
  end

  always_comb begin
    accept = 1'b0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (rd_en && rd_buf == BW'(b) && done[b]) accept = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 1'b0;
      sel_q <= '0;
    end else begin
      acc_q <= accept;
      sel_q <= rd_buf;
    end
  end

  iq_hist_rdsel #(
    .NUM_BUF(NUM_BUF),
    .W      (EW)
  ) u_rdsel (
    .clk    (clk),
    .rst    (rst),
    .take_i (acc_q),
    .sel_i  (sel_q),
    .bank_i (bank_rd),
    .valid_o(rd_valid),
    .data_o (rd_word)
  );

  assign rd_i = rd_word[EW-1:DW];
  assign rd_q = rd_word[DW-1:0];

  AST_RD_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en, 2)); // R7
  AST_RD_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_i == '0 && rd_q == '0)); // R7

endmodule

// File: tb/sim_iq_history_capture.sv
module sim_iq_history_capture;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 3;
  localparam int D     = 16;
  localparam int DW    = 16;
  localparam int ZW    = 3;
  localparam int PW    = 4;
  localparam int AW    = 4;
  localparam int BW    = 2;
  localparam int NSTEP = 130;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [NB*DW-1:0] in_i, in_q;
  logic             trigger;
  logic [NB-1:0]    arm;
  logic [NB*ZW-1:0] zoom;
  logic [NB*PW-1:0] pan;
  logic [NB-1:0]    done;
  logic             rd_en;
  logic [BW-1:0]    rd_buf;
  logic [AW-1:0]    rd_addr;
  logic             rd_valid;
  logic [DW-1:0]    rd_i, rd_q;

  int n_checks = 0;
  int n_fail   = 0;
  int n_global = 0;
  int n_first  = 0;
  int cfg_z [NB];
  int cfg_p [NB];
  int cnt   [NB];
  bit trig_seen [NB];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_history_capture #(
    .NUM_BUF(NB), .DEPTH(D), .DW(DW), .ZOOM_W(ZW), .PAN_W(PW)
  ) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .trigger(trigger), .arm(arm), .zoom(zoom), .pan(pan), .done(done),
    .rd_en(rd_en), .rd_buf(rd_buf), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_i(rd_i), .rd_q(rd_q)
  );

  function automatic logic [DW-1:0] exp_i(input int b, input int n);
    return DW'(n * 7 + b * 311);
  endfunction

  function automatic logic [DW-1:0] exp_q(input int b, input int n);
    return DW'(n * 13 + b * 97) ^ 16'h5A5A;
  endfunction

  function automatic int zeff(input int b);
    return (cfg_z[b] == 0) ? 1 : cfg_z[b];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input bit v, input bit t, input logic [NB-1:0] a);
    in_valid = v;
    trigger  = t;
    arm      = a;
    for (int b = 0; b < NB; b++) begin
      in_i[b*DW +: DW] = exp_i(b, n_global);
      in_q[b*DW +: DW] = exp_q(b, n_global);
    end
    @(posedge clk);
    if (v) n_global++;
    @(negedge clk);
    in_valid = 1'b0;
    trigger  = 1'b0;
    arm      = '0;
  endtask

  task automatic check_done();
    for (int b = 0; b < NB; b++) begin
      bit e;
      e = trig_seen[b] && (cnt[b] > cfg_p[b] + (D - 1) * zeff(b));
      chk(done[b] == e, "R5 done timing", int'(done[b]), int'(e));
    end
  endtask

  task automatic rd(input int b, input int a, output logic v,
                    output logic [DW-1:0] ri, output logic [DW-1:0] rq);
    rd_en   = 1'b1;
    rd_buf  = BW'(b);
    rd_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v  = rd_valid;
    ri = rd_i;
    rq = rd_q;
  endtask

  task automatic check_entry(input int b, input int j);
    logic v;
    logic [DW-1:0] ri, rq;
    int idx;
    idx = n_first + cfg_p[b] + j * zeff(b);
    rd(b, j, v, ri, rq);
    chk(v == 1'b1, "R7 read of done lane", int'(v), 1);
    if (j == 0) chk(ri == exp_i(b, idx), "R3 first entry I", int'(ri), int'(exp_i(b, idx)));
    else        chk(ri == exp_i(b, idx), "R4 R8 decimated entry I", int'(ri), int'(exp_i(b, idx)));
    chk(rq == exp_q(b, idx), "R6 entry Q", int'(rq), int'(exp_q(b, idx)));
  endtask

  task automatic run(input int zsel, input int psel);
    bit gappy, retrig;
    gappy  = (zsel % 2) == 1;
    retrig = (psel == 1);
    for (int b = 0; b < NB; b++) begin
      cfg_z[b] = (zsel + b) % 5;
      cfg_p[b] = (psel * 5 + b * 3) % 16;
      zoom[b*ZW +: ZW] = ZW'(cfg_z[b]);
      pan[b*PW +: PW]  = PW'(cfg_p[b]);
      trig_seen[b] = 1'b0;
      cnt[b] = 0;
    end
    step(1'b0, 1'b0, '1);
    chk(done == '0, "R2 arm clears done", int'(done), 0);
    repeat (3) begin
      step(1'b1, 1'b0, '0);
      check_done();
    end
    step(1'b1, 1'b1, '0);
    n_first = n_global;
    for (int b = 0; b < NB; b++) trig_seen[b] = 1'b1;
    check_done();
    for (int s = 0; s < NSTEP; s++) begin
      bit v, t;
      v = gappy ? ((s % 3) != 1) : 1'b1;
      t = retrig && (s == 7);
      if (psel == 2 && s == 3) zoom = '1;
      step(v, t, '0);
      if (v) for (int b = 0; b < NB; b++) cnt[b]++;
      check_done();
    end
    for (int b = 0; b < NB; b++)
      for (int j = 0; j < D; j++) check_entry(b, j);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [DW-1:0] ri, rq;
    rst = 1'b1; in_valid = 1'b0; trigger = 1'b0; arm = '0;
    in_i = '0; in_q = '0; zoom = '0; pan = '0;
    rd_en = 1'b0; rd_buf = '0; rd_addr = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(done == '0, "R1 done after reset", int'(done), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    chk(rd_i == '0 && rd_q == '0, "R1 read data after reset", int'(rd_i), 0);

    rd(0, 0, v, ri, rq);
    chk(v == 1'b0, "R7 read before capture", int'(v), 0);
    chk(ri == '0 && rq == '0, "R7 data zero when not valid", int'(ri), 0);

    step(1'b1, 1'b1, '0);
    repeat (40) step(1'b1, 1'b0, '0);
    chk(done == '0, "R2 trigger without arm ignored", int'(done), 0);

    for (int z = 0; z < 5; z++)
      for (int p = 0; p < 3; p++) begin
        run(z, p);
        if (p == 1) chk(done == '1, "R9 retrigger ignored, all lanes done", int'(done), 7);
      end

    rd(3, 0, v, ri, rq);
    chk(v == 1'b0, "R7 nonexistent lane rejected", int'(v), 0);

    step(1'b0, 1'b0, 3'b001);
    chk(done[0] == 1'b0, "R2 re-arm clears lane 0", int'(done[0]), 0);
    chk(done[2:1] == 2'b11, "R8 other lanes keep done", int'(done[2:1]), 3);
    rd(0, 2, v, ri, rq);
    chk(v == 1'b0, "R7 read of re-armed lane rejected", int'(v), 0);
    check_entry(1, 5);
    check_entry(2, D - 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule